// File: doc/BRIEF.md
# Master-Clock Ratio Detector

This block sits beside an audio serial port and works out how many master-clock cycles make up one sample period. It counts master-clock cycles between successive rising edges of the word clock and maps the count onto a small set of allowed ratios. It also reports whether the signal path should oversample at 64fs or 128fs. A converter core can use the result to set up its filters without any software involvement.

In slave mode the word clock is an input, and the block measures it after a two-flop synchroniser. In master mode the ratio comes straight from a rate-select field and the measurement is ignored. A strap selects whether the block serves a playback (DAC) path or a capture (ADC) path. The capture path accepts fewer ratios and has its own force-64fs control.

Top module: `mclk_ratio_detect`

## Requirements
- R1: The ratio output uses codes 0=128, 1=192, 2=256, 3=384, 4=512 and 5=768 master clocks per sample, and never shows a value above 5. On the DAC path all six ratios are recognised.
- R2: On the ADC path (`adc_path_i`=1) only codes 2 to 5 can be detected. A period near 128 or 192 clocks counts as a mismatch.
- R3: A measured period matches a ratio when it lies within 32 clocks of that ratio's nominal count, inclusive at both ends. Where two windows overlap, the lower code wins.
- R4: A completed measurement that matches no allowed ratio gives code 5 with `err_o`=1. A measurement that matches gives `err_o`=0.
- R5: With `slave_mode_i`=0, the ratio follows `rate_sel_i` on the next clock, with values 6 and 7 read as 5. In this mode `err_o`=0, `valid_o`=1, and the word clock has no effect.
- R6: On the DAC path, `osr64_o` is 1 exactly when the ratio output is code 0 or 1. Otherwise it is 0.
- R7: On the ADC path, `osr64_o` equals `adc_osr64_i` regardless of the ratio.
- R8: In slave mode a new measured result reaches the outputs only after two consecutive periods classify to the same code and error state. `valid_o` is 0 from reset until the first output is committed, and once high it stays high.
- R9: The period counter stops at 1023. When it reaches 1023 without a word-clock edge, code 5 with `err_o`=1 is committed at once, and the next rising edge only restarts measurement.
- R10: A period runs from one synchronised rising word-clock edge to the next. The first edge after reset, after master mode or after a saturation only starts the count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Master clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| lrc_i | input | 1 | Word clock, asynchronous to `clk_i` |
| slave_mode_i | input | 1 | 1 = measure word clock, 0 = take ratio from `rate_sel_i` |
| rate_sel_i | input | 3 | Ratio code used in master mode |
| adc_path_i | input | 1 | 0 = DAC ratio set, 1 = ADC ratio set |
| adc_osr64_i | input | 1 | ADC path: force 64fs oversampling |
| ratio_o | output | 3 | Ratio code |
| valid_o | output | 1 | A ratio has been committed since reset |
| err_o | output | 1 | Committed ratio is the mismatch or lost-clock default |
| osr64_o | output | 1 | 1 = 64fs oversampling, 0 = 128fs |

## Verification
Two events can meet on one edge: a commit from two matching periods, and a saturation default, or a change of mode. The bench forces these together by stopping the word clock right after a committed period, and by switching to master mode while periods are still being measured. It then checks that the default or the rate-select value alone appears at the outputs. It also walks periods exactly on window edges and in overlap zones. The overlap cases are judged by the lower-code rule.

// File: rtl/mclk_ratio_pkg.sv
package mclk_ratio_pkg;

    localparam int NUM_RATIOS   = 6;
    localparam int ADC_MIN_CODE = 2;

    typedef enum logic [2:0] {
        RATIO_128 = 3'd0,
        RATIO_192 = 3'd1,
        RATIO_256 = 3'd2,
        RATIO_384 = 3'd3,
        RATIO_512 = 3'd4,
        RATIO_768 = 3'd5
    } ratio_e;

    // even codes are powers of two from 128, odd codes are 1.5x that
    function automatic int ratio_nominal(input int code);
        int base;
        base = 128 << (code / 2);
        return (code % 2 == 0) ? base : (base * 3) / 2;
    endfunction

endpackage

// File: rtl/lrc_edge_sync.sv
module lrc_edge_sync #(
    parameter int STAGES = 2
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic lrc_i,
    output logic rise_o
);
    logic [STAGES-1:0] sync_d, sync_q;
    logic              prev_d, prev_q;

    always_comb begin
        sync_d = {sync_q[STAGES-2:0], lrc_i};
        prev_d = sync_q[STAGES-1];
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            sync_q <= '0;
            prev_q <= 1'b0;
        end else begin
            sync_q <= sync_d;
            prev_q <= prev_d;
        end
    end

    assign rise_o = sync_q[STAGES-1] & ~prev_q;
endmodule

// File: rtl/period_counter.sv
module period_counter #(
    parameter int CNT_W = 10
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             rise_i,
    output logic [CNT_W-1:0] count_o,
    output logic             sat_hit_o
);
    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

    logic [CNT_W-1:0] count_d, count_q;

    always_comb begin
        if (rise_i)
            count_d = '0;
        else if (count_q == CNT_MAX)
            count_d = CNT_MAX;
        else
            count_d = count_q + 1'b1;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) count_q <= '0;
        else         count_q <= count_d;
    end

    assign count_o   = count_q;
    assign sat_hit_o = ~rise_i && (count_q == CNT_MAX - 1'b1);
endmodule

// File: rtl/ratio_classifier.sv
module ratio_classifier
    import mclk_ratio_pkg::*;
#(
    parameter int CNT_W = 10,
    parameter int TOL   = 32
) (
    input  logic [CNT_W-1:0] period_i,
    input  logic             adc_path_i,
    output ratio_e           code_o,
    output logic             nomatch_o
);
    logic [NUM_RATIOS-1:0] hit;

    for (genvar i = 0; i < NUM_RATIOS; i++) begin : g_win
        localparam int  NOM    = ratio_nominal(i);
        localparam bit  ADC_OK = (i >= ADC_MIN_CODE);
        int diff;
        assign diff   = int'(period_i) - NOM;
        assign hit[i] = (diff >= -TOL) && (diff <= TOL) && (!adc_path_i || ADC_OK);
    end

    always_comb begin
        code_o    = RATIO_768;
        nomatch_o = 1'b1;
        for (int i = NUM_RATIOS - 1; i >= 0; i--) begin
            if (hit[i]) begin
                code_o    = ratio_e'(3'(i));
                nomatch_o = 1'b0;
            end
        end
    end
endmodule

// File: rtl/mclk_ratio_detect.sv
module mclk_ratio_detect
    import mclk_ratio_pkg::*;
#(
    parameter int CNT_W       = 10,
    parameter int TOL         = 32,
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk_i,
    input  logic       rst_ni,
    input  logic       lrc_i,
    input  logic       slave_mode_i,
    input  logic [2:0] rate_sel_i,
    input  logic       adc_path_i,
    input  logic       adc_osr64_i,
    output logic [2:0] ratio_o,
    output logic       valid_o,
    output logic       err_o,
    output logic       osr64_o
);
    typedef struct packed {
        logic   armed;
        logic   have_last;
        ratio_e last_code;
        logic   last_err;
        ratio_e ratio;
        logic   valid;
        logic   err;
        logic   osr64;
    } det_state_t;

    localparam det_state_t RESET_STATE = '{
        armed: 1'b0, have_last: 1'b0, last_code: RATIO_768, last_err: 1'b0,
        ratio: RATIO_768, valid: 1'b0, err: 1'b0, osr64: 1'b0
    };

    logic             rise;
    logic [CNT_W-1:0] count;
    logic [CNT_W-1:0] period;
    logic             sat_hit;
    ratio_e           cls_code;
    logic             cls_err;
    det_state_t       st_d, st_q;

    lrc_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .lrc_i  (lrc_i),
        .rise_o (rise)
    );

    period_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .rise_i    (rise),
        .count_o   (count),
        .sat_hit_o (sat_hit)
    );

    // count holds cycles since last edge minus one
    assign period = count + 1'b1;

    ratio_classifier #(.CNT_W(CNT_W), .TOL(TOL)) u_cls (
        .period_i   (period),
        .adc_path_i (adc_path_i),
        .code_o     (cls_code),
        .nomatch_o  (cls_err)
    );

    always_comb begin
        st_d = st_q;
        if (!slave_mode_i) begin
            st_d.armed     = 1'b0;
            st_d.have_last = 1'b0;
            st_d.ratio     = (rate_sel_i > 3'd5) ? RATIO_768 : ratio_e'(rate_sel_i);
            st_d.err       = 1'b0;
            st_d.valid     = 1'b1;
        end else if (sat_hit) begin
            st_d.armed     = 1'b0;
            st_d.have_last = 1'b0;
            st_d.ratio     = RATIO_768;
            st_d.err       = 1'b1;
            st_d.valid     = 1'b1;
        end else if (rise) begin
            if (!st_q.armed) begin
                st_d.armed = 1'b1;
            end else begin
                if (st_q.have_last && st_q.last_code == cls_code && st_q.last_err == cls_err) begin
                    st_d.ratio = cls_code;
                    st_d.err   = cls_err;
                    st_d.valid = 1'b1;
                end
                st_d.have_last = 1'b1;
                st_d.last_code = cls_code;
                st_d.last_err  = cls_err;
            end
        end
        st_d.osr64 = adc_path_i ? adc_osr64_i : (st_d.ratio <= RATIO_192);
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) st_q <= RESET_STATE;
        else         st_q <= st_d;
    end

    assign ratio_o = st_q.ratio;
    assign valid_o = st_q.valid;
    assign err_o   = st_q.err;
    assign osr64_o = st_q.osr64;
endmodule

// File: rtl/mclk_ratio_detect_chk.sv
module mclk_ratio_detect_chk (
    input logic       clk_i,
    input logic       rst_ni,
    input logic       slave_mode_i,
    input logic [2:0] rate_sel_i,
    input logic       adc_path_i,
    input logic       adc_osr64_i,
    input logic [2:0] ratio_o,
    input logic       valid_o,
    input logic       err_o,
    input logic       osr64_o
);
    AST_RATIO_LEGAL: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ratio_o <= 3'd5);                                                     // R1

    AST_ERR_FORCES_768: assert property (@(posedge clk_i) disable iff (!rst_ni)
        err_o |-> ratio_o == 3'd5);                                           // R4

    AST_VALID_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
        valid_o |=> valid_o);                                                 // R8

    AST_MASTER_FOLLOWS_SEL: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ($past(rst_ni) && !$past(slave_mode_i)) |->
            (ratio_o == (($past(rate_sel_i) > 3'd5) ? 3'd5 : $past(rate_sel_i)) && !err_o && valid_o)); // R5

    AST_DAC_OSR: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ($past(rst_ni) && !$past(adc_path_i)) |-> (osr64_o == (ratio_o <= 3'd1))); // R6

    AST_ADC_OSR: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ($past(rst_ni) && $past(adc_path_i)) |-> (osr64_o == $past(adc_osr64_i))); // R7
endmodule

bind mclk_ratio_detect mclk_ratio_detect_chk u_chk (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .slave_mode_i (slave_mode_i),
    .rate_sel_i   (rate_sel_i),
    .adc_path_i   (adc_path_i),
    .adc_osr64_i  (adc_osr64_i),
    .ratio_o      (ratio_o),
    .valid_o      (valid_o),
    .err_o        (err_o),
    .osr64_o      (osr64_o)
);

// File: tb/mclk_ratio_detect_tb.sv
module mclk_ratio_detect_tb;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       lrc = 1'b0;
    logic       slave = 1'b1;
    logic [2:0] rate_sel = 3'd0;
    logic       adc_path = 1'b0;
    logic       adc_force = 1'b0;
    logic [2:0] ratio;
    logic       valid, err, osr64;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #2.5 clk = ~clk;

    mclk_ratio_detect u_dut (
        .clk_i        (clk),
        .rst_ni       (rst_n),
        .lrc_i        (lrc),
        .slave_mode_i (slave),
        .rate_sel_i   (rate_sel),
        .adc_path_i   (adc_path),
        .adc_osr64_i  (adc_force),
        .ratio_o      (ratio),
        .valid_o      (valid),
        .err_o        (err),
        .osr64_o      (osr64)
    );

    typedef struct packed {
        logic        adc;
        logic [10:0] period;
        logic [2:0]  code;
        logic        err;
    } vec_t;

    localparam int NVEC = 17;
    localparam vec_t VECS [NVEC] = '{
        '{1'b0, 11'd128,  3'd0, 1'b0},   // R1
        '{1'b0, 11'd192,  3'd1, 1'b0},   // R1
        '{1'b0, 11'd256,  3'd2, 1'b0},   // R1
        '{1'b0, 11'd384,  3'd3, 1'b0},   // R1
        '{1'b0, 11'd512,  3'd4, 1'b0},   // R1
        '{1'b0, 11'd768,  3'd5, 1'b0},   // R1
        '{1'b0, 11'd160,  3'd0, 1'b0},   // R3 overlap -> lower
        '{1'b0, 11'd224,  3'd1, 1'b0},   // R3 overlap -> lower
        '{1'b0, 11'd96,   3'd0, 1'b0},   // R3 lower edge
        '{1'b0, 11'd95,   3'd5, 1'b1},   // R4 just outside
        '{1'b0, 11'd800,  3'd5, 1'b0},   // R3 upper edge
        '{1'b0, 11'd801,  3'd5, 1'b1},   // R4
        '{1'b0, 11'd600,  3'd5, 1'b1},   // R4 gap
        '{1'b1, 11'd128,  3'd5, 1'b1},   // R2
        '{1'b1, 11'd192,  3'd5, 1'b1},   // R2
        '{1'b1, 11'd224,  3'd2, 1'b0},   // R2 edge of 256
        '{1'b1, 11'd768,  3'd5, 1'b0}    // R2
    };

    task automatic check(input string req, input logic [2:0] e_ratio, input logic e_valid,
                         input logic e_err, input logic e_osr);
        n_checks++;
        if (ratio !== e_ratio || valid !== e_valid || err !== e_err || osr64 !== e_osr) begin
            n_fail++;
            $display("FAIL %s: got ratio=%0d valid=%0b err=%0b osr64=%0b, expected ratio=%0d valid=%0b err=%0b osr64=%0b",
                     req, ratio, valid, err, osr64, e_ratio, e_valid, e_err, e_osr);
        end
    endtask

    task automatic run_periods(input int p, input int n);
        for (int k = 0; k < n; k++) begin
            lrc = 1'b1;
            repeat (p / 2) @(negedge clk);
            lrc = 1'b0;
            repeat (p - p / 2) @(negedge clk);
        end
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        idle(4);
        check("R8 reset", 3'd5, 1'b0, 1'b0, 1'b0);
        rst_n = 1'b1;
        idle(2);

        // first edge arms, second edge measures once: nothing committed yet
        run_periods(256, 2);
        check("R10 first edge arms", 3'd5, 1'b0, 1'b0, 1'b0);
        run_periods(256, 1);
        check("R8 first commit", 3'd2, 1'b1, 1'b0, 1'b0);

        for (int i = 0; i < NVEC; i++) begin
            adc_path = VECS[i].adc;
            run_periods(int'(VECS[i].period), 4);
            check($sformatf("R1/R2/R3/R4 vec%0d p=%0d", i, VECS[i].period),
                  VECS[i].code, 1'b1, VECS[i].err,
                  VECS[i].adc ? 1'b0 : (VECS[i].code <= 3'd1));
        end

        // R8: one odd period does not move the output
        adc_path = 1'b0;
        run_periods(256, 4);
        run_periods(512, 2);
        check("R8 single period held", 3'd2, 1'b1, 1'b0, 1'b0);
        run_periods(512, 1);
        check("R8 two periods commit", 3'd4, 1'b1, 1'b0, 1'b0);

        // R6 with 192 ratio
        run_periods(192, 4);
        check("R6 osr64 at 192", 3'd1, 1'b1, 1'b0, 1'b1);

        // R9: lost word clock right after a commit
        run_periods(256, 4);
        idle(700);
        check("R9 before saturation", 3'd2, 1'b1, 1'b0, 1'b0);
        idle(400);
        check("R9 saturated", 3'd5, 1'b1, 1'b1, 1'b0);
        run_periods(256, 2);
        check("R9 R10 rearm only", 3'd5, 1'b1, 1'b1, 1'b0);
        run_periods(256, 1);
        check("R9 recovered", 3'd2, 1'b1, 1'b0, 1'b0);

        // R5: master mode, word clock ignored
        slave = 1'b0;
        rate_sel = 3'd4;
        run_periods(128, 3);
        check("R5 master sel=4", 3'd4, 1'b1, 1'b0, 1'b0);
        rate_sel = 3'd1;
        idle(2);
        check("R5 R6 master sel=1", 3'd1, 1'b1, 1'b0, 1'b1);
        rate_sel = 3'd7;
        idle(2);
        check("R5 master sel=7", 3'd5, 1'b1, 1'b0, 1'b0);

        // R7: ADC path ignores ratio for osr
        adc_path = 1'b1;
        rate_sel = 3'd0;
        adc_force = 1'b0;
        idle(2);
        check("R7 adc no force at code0", 3'd0, 1'b1, 1'b0, 1'b0);
        adc_force = 1'b1;
        idle(2);
        check("R7 adc force", 3'd0, 1'b1, 1'b0, 1'b1);

        // back to slave: history restarts, master value held until commit
        slave = 1'b1;
        rate_sel = 3'd3;
        run_periods(384, 2);
        check("R10 slave re-entry held", 3'd0, 1'b1, 1'b0, 1'b1);
        run_periods(384, 1);
        check("R7 R2 slave adc 384", 3'd3, 1'b1, 1'b0, 1'b1);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        #(5.0 * 190000);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: got timeout, expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end
endmodule